// File: doc/BRIEF.md
# Free-Running Timer with Capture, Compare and Status Flags

This block is a 16-bit up-counter that advances on each prescaler clock-enable pulse. Two compare channels watch it for a match. Two capture channels take a copy of it when their pin rises. A status register collects four event flags, and software reaches the whole block through an 8-bit register port. The port has an address, a read strobe and a write strobe. Read data is combinational, so it is valid in the same cycle as the read strobe. Register side effects take place at the clock edge that ends the access.

A flag is cleared in two steps. First software reads the status register, which arms every flag that is 1 at that moment. Then software reads or writes the low byte of the register that owns the flag, which clears that flag if it is armed. Each flag has a small clear sequencer with two states:
- `CLR_IDLE` moves to `CLR_ARMED` on a status read while the flag is 1.
- `CLR_ARMED` stays in `CLR_ARMED` on another status read while the flag is 1.
- `CLR_ARMED` returns to `CLR_IDLE` on an access to the flag's own low byte.
- Either state goes to `CLR_IDLE` on a status read while the flag is 0.

A halt bit stops the counter and holds both compare pins low. Every register stays readable and writable while the block is halted.

Top module: `tmr_fr_top`

## Requirements
- R1: After reset, the status register, the control register and the counter all read 0, and both compare pins are 0.
- R2: While running, the counter increments by one on each cycle in which `tick` is 1. The overflow flag (status bit 0) sets on the step from 16'hFFFF to 16'h0000.
- R3: Compare flag 0 (status bit 1) and compare flag 1 (status bit 2) set on the step where the counter takes the value held in that channel's compare register. Compare pin N is 1 while compare flag N is set and the block is not halted.
- R4: A rising edge on a capture pin passes through a two-flop synchronizer and then loads the counter into that channel's read-only capture register. This also works while the block is halted. A capture on channel 1 sets status bit 3.
- R5: A flag clears only after a status read that saw it at 1, followed by a read or write of its own low byte. Those low bytes are: counter low (3) for overflow, compare low bytes (7, 9) for the compare flags, and capture 1 low (13) for the capture flag. An access to another flag's low byte leaves it set.
- R6: A read of the alias counter low byte (address 5) never clears the overflow flag.
- R7: A flag that sets after the last status read is not cleared by its low-byte access.
- R8: When a flag's set event and its clearing access fall in the same cycle, the flag stays set.
- R9: Control bit 0 (address 1) halts the counter and forces both compare pins to 0. The other control bits read 0. A write to address 3 or 5 resets the counter to 0, and this works whether or not the block is halted.
- R10: A read of the counter high byte (address 2 or 4) latches the low byte. The next counter low-byte read returns that latched value. Writes to the high bytes are ignored.
- R11: Register map: 0 status, 1 control, 2/3 counter high/low, 4/5 alias counter high/low, 6/7 and 8/9 compare 0/1 high/low, 10/11 and 12/13 capture 0/1 high/low. Status bits 7:4 and addresses 14 and 15 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Prescaler clock enable; the counter steps when it is 1 |
| addr | input | 4 | Register address |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from addr |
| cap0_pin | input | 1 | Capture channel 0 pin |
| cap1_pin | input | 1 | Capture channel 1 pin |
| cmp0_out | output | 1 | Compare channel 0 pin |
| cmp1_out | output | 1 | Compare channel 1 pin |

## Verification
The collision that matters is a compare match landing in the same clock edge as the low-byte access meant to clear that match flag. The bench arms compare flag 0 with a status read. It then sets the counter one step short of the compare value and issues the compare low-byte read with `tick` held high in that same cycle. The expected result is a flag that is still set: the compare pin stays at 1 and the status register still shows bit 1. A second status read followed by the low-byte access must then clear it.

// File: rtl/tmr_fr_pkg.sv
package tmr_fr_pkg;

    typedef enum logic [3:0] {
        RA_STAT    = 4'd0,
        RA_CTRL    = 4'd1,
        RA_CNT_HI  = 4'd2,
        RA_CNT_LO  = 4'd3,
        RA_ALT_HI  = 4'd4,
        RA_ALT_LO  = 4'd5,
        RA_CMP0_HI = 4'd6,
        RA_CMP0_LO = 4'd7,
        RA_CMP1_HI = 4'd8,
        RA_CMP1_LO = 4'd9,
        RA_CAP0_HI = 4'd10,
        RA_CAP0_LO = 4'd11,
        RA_CAP1_HI = 4'd12,
        RA_CAP1_LO = 4'd13
    } reg_addr_e;

    localparam int NCMP    = 2;
    localparam int NCAP    = 2;
    localparam int NFLAG   = 4;
    localparam int FL_OVF  = 0;
    localparam int FL_CMP0 = 1;
    localparam int FL_CMP1 = 2;
    localparam int FL_CAP1 = 3;

    typedef enum logic {
        CLR_IDLE,
        CLR_ARMED
    } clr_state_e;

endpackage

// File: rtl/tmr_fr_counter.sv
module tmr_fr_counter #(
    parameter int CW   = 16,
    parameter int NCH  = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          halt,
    input  logic          clear,
    input  logic [CW-1:0] cmp_val [NCH],
    output logic [CW-1:0] cnt,
    output logic          ovf_ev,
    output logic [NCH-1:0] cmp_ev
);
    localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};
    localparam logic [CW-1:0] CNT_ONE = {{(CW-1){1'b0}}, 1'b1};

    logic          step;
    logic [CW-1:0] cnt_inc;

    assign step    = tick & ~halt & ~clear;
    assign cnt_inc = cnt + CNT_ONE;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (step) begin
            cnt <= cnt_inc;
        end
    end

    assign ovf_ev = step & (cnt == CNT_MAX);

    for (genvar g = 0; g < NCH; g++) begin : g_cmp
        assign cmp_ev[g] = step & (cnt_inc == cmp_val[g]);
    end

    // R9: halted counter holds unless a reset write arrives
    p_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !clear) |=> $stable(cnt));

    // R9: a reset write zeroes the counter
    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cnt == '0));

    // R2: each enabled tick advances by one
    p_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !halt && !clear) |=> (cnt == $past(cnt) + CNT_ONE));

endmodule

// File: rtl/tmr_fr_capture.sv
module tmr_fr_capture #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pin,
    input  logic [CW-1:0] cnt,
    output logic          ev,
    output logic [CW-1:0] cap_q
);
    logic s1_q, s2_q, s3_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
            s3_q <= 1'b0;
        end else begin
            s1_q <= pin;
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    assign ev = s2_q & ~s3_q;

    // capture register has no defined reset value
    always_ff @(posedge clk) begin
        if (ev) begin
            cap_q <= cnt;
        end
    end

    // R4: the capture register holds the counter seen at the event
    p_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ev |=> (cap_q == $past(cnt)));

endmodule

// File: rtl/tmr_fr_flag.sv
module tmr_fr_flag
    import tmr_fr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_ev,
    input  logic stat_rd,
    input  logic clr_acc,
    output logic flag
);
    clr_state_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CLR_IDLE: begin
                if (stat_rd && flag) st_d = CLR_ARMED;
            end
            CLR_ARMED: begin
                if (stat_rd)      st_d = flag ? CLR_ARMED : CLR_IDLE;
                else if (clr_acc) st_d = CLR_IDLE;
            end
            default: st_d = CLR_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= CLR_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (set_ev) begin
            flag <= 1'b1;
        end else if (clr_acc && st_q == CLR_ARMED) begin
            flag <= 1'b0;
        end
    end

    // R8: a set event always leaves the flag set
    p_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        set_ev |=> flag);

    // R5: armed clear access without a set event clears
    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CLR_ARMED && clr_acc && !set_ev) |=> !flag);

    // R7: an unarmed flag survives any access
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && st_q == CLR_IDLE) |=> flag);

endmodule

// File: rtl/tmr_fr_top.sv
module tmr_fr_top
    import tmr_fr_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic [3:0]    addr,
    input  logic          rd,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    input  logic          cap0_pin,
    input  logic          cap1_pin,
    output logic          cmp0_out,
    output logic          cmp1_out
);
    localparam int CW = 2 * DW;

    reg_addr_e      ra;
    logic           acc;
    logic           halt_q;
    logic           cnt_clear;
    logic [CW-1:0]  cnt;
    logic           ovf_ev;
    logic [NCMP-1:0] cmp_ev;
    logic [CW-1:0]  cmp_q [NCMP];
    logic [NCAP-1:0] cap_pin;
    logic [NCAP-1:0] cap_ev;
    logic [CW-1:0]  cap_val [NCAP];
    logic [DW-1:0]  lat_q;
    logic           lat_vld;
    logic [DW-1:0]  cnt_lo_view;
    logic           stat_rd;
    logic [NFLAG-1:0] set_vec;
    logic [NFLAG-1:0] clr_vec;
    logic [NFLAG-1:0] flags;

    assign ra  = reg_addr_e'(addr);
    assign acc = rd | wr;

    // control register
    always_ff @(posedge clk) begin
        if (!rst_n)                     halt_q <= 1'b0;
        else if (wr && ra == RA_CTRL)   halt_q <= wdata[0];
    end

    assign cnt_clear = wr && (ra == RA_CNT_LO || ra == RA_ALT_LO);

    // compare registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int g = 0; g < NCMP; g++) cmp_q[g] <= '0;
        end else if (wr) begin
            for (int g = 0; g < NCMP; g++) begin
                if (int'(addr) == int'(RA_CMP0_HI) + 2 * g) cmp_q[g][CW-1:DW] <= wdata;
                if (int'(addr) == int'(RA_CMP0_LO) + 2 * g) cmp_q[g][DW-1:0]  <= wdata;
            end
        end
    end

    tmr_fr_counter #(
        .CW  (CW),
        .NCH (NCMP)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .halt    (halt_q),
        .clear   (cnt_clear),
        .cmp_val (cmp_q),
        .cnt     (cnt),
        .ovf_ev  (ovf_ev),
        .cmp_ev  (cmp_ev)
    );

    assign cap_pin = {cap1_pin, cap0_pin};

    for (genvar g = 0; g < NCAP; g++) begin : g_cap
        tmr_fr_capture #(
            .CW (CW)
        ) u_cap (
            .clk   (clk),
            .rst_n (rst_n),
            .pin   (cap_pin[g]),
            .cnt   (cnt),
            .ev    (cap_ev[g]),
            .cap_q (cap_val[g])
        );
    end

    // low byte latch for coherent counter reads
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_q   <= '0;
            lat_vld <= 1'b0;
        end else if (rd && (ra == RA_CNT_HI || ra == RA_ALT_HI)) begin
            lat_q   <= cnt[DW-1:0];
            lat_vld <= 1'b1;
        end else if (rd && (ra == RA_CNT_LO || ra == RA_ALT_LO)) begin
            lat_vld <= 1'b0;
        end
    end

    assign cnt_lo_view = lat_vld ? lat_q : cnt[DW-1:0];

    // status flags and their clear sequencers
    assign stat_rd = rd && (ra == RA_STAT);

    always_comb begin
        set_vec          = '0;
        set_vec[FL_OVF]  = ovf_ev;
        set_vec[FL_CMP0] = cmp_ev[0];
        set_vec[FL_CMP1] = cmp_ev[1];
        set_vec[FL_CAP1] = cap_ev[1];
        clr_vec          = '0;
        clr_vec[FL_OVF]  = acc && (ra == RA_CNT_LO);
        clr_vec[FL_CMP0] = acc && (ra == RA_CMP0_LO);
        clr_vec[FL_CMP1] = acc && (ra == RA_CMP1_LO);
        clr_vec[FL_CAP1] = acc && (ra == RA_CAP1_LO);
    end

    for (genvar g = 0; g < NFLAG; g++) begin : g_flag
        tmr_fr_flag u_flag (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_ev  (set_vec[g]),
            .stat_rd (stat_rd),
            .clr_acc (clr_vec[g]),
            .flag    (flags[g])
        );
    end

    assign cmp0_out = flags[FL_CMP0] & ~halt_q;
    assign cmp1_out = flags[FL_CMP1] & ~halt_q;

    // read mux
    always_comb begin
        rdata = '0;
        unique case (ra)
            RA_STAT:    rdata = {{(DW-NFLAG){1'b0}}, flags};
            RA_CTRL:    rdata = {{(DW-1){1'b0}}, halt_q};
            RA_CNT_HI,
            RA_ALT_HI:  rdata = cnt[CW-1:DW];
            RA_CNT_LO,
            RA_ALT_LO:  rdata = cnt_lo_view;
            RA_CMP0_HI: rdata = cmp_q[0][CW-1:DW];
            RA_CMP0_LO: rdata = cmp_q[0][DW-1:0];
            RA_CMP1_HI: rdata = cmp_q[1][CW-1:DW];
            RA_CMP1_LO: rdata = cmp_q[1][DW-1:0];
            RA_CAP0_HI: rdata = cap_val[0][CW-1:DW];
            RA_CAP0_LO: rdata = cap_val[0][DW-1:0];
            RA_CAP1_HI: rdata = cap_val[1][CW-1:DW];
            RA_CAP1_LO: rdata = cap_val[1][DW-1:0];
            default:    rdata = '0;
        endcase
    end

    // R6: alias low byte access with no overflow event keeps the flag
    p_alias_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[FL_OVF] && acc && ra == RA_ALT_LO) |=> flags[FL_OVF]);

    // R4: channel 0 capture never raises a status flag by itself
    p_cap0_noflag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_ev[0] && !cap_ev[1] && !flags[FL_CAP1]) |=> !flags[FL_CAP1]);

endmodule

// File: tb/tmr_fr_top_tb.sv
module tmr_fr_top_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [3:0] addr = '0;
    logic       rd = 1'b0;
    logic       wr = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       cap0_pin = 1'b0;
    logic       cap1_pin = 1'b0;
    logic       cmp0_out;
    logic       cmp1_out;

    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    tmr_fr_top dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .addr     (addr),
        .rd       (rd),
        .wr       (wr),
        .wdata    (wdata),
        .rdata    (rdata),
        .cap0_pin (cap0_pin),
        .cap1_pin (cap1_pin),
        .cmp0_out (cmp0_out),
        .cmp1_out (cmp1_out)
    );

    // entry: {write, addr, wdata, expected, requirement number}
    localparam int NV = 20;
    localparam logic [24:0] TBL [NV] = '{
        {1'b0, 4'd0,  8'h00, 8'h00, 4'd1},   // R1 status
        {1'b0, 4'd1,  8'h00, 8'h00, 4'd1},   // R1 control
        {1'b0, 4'd2,  8'h00, 8'h00, 4'd1},   // R1 counter high
        {1'b0, 4'd3,  8'h00, 8'h00, 4'd1},   // R1 counter low
        {1'b1, 4'd6,  8'hA5, 8'h00, 4'd11},
        {1'b1, 4'd7,  8'h3C, 8'h00, 4'd11},
        {1'b0, 4'd6,  8'h00, 8'hA5, 4'd11},  // R11 compare 0
        {1'b0, 4'd7,  8'h00, 8'h3C, 4'd11},
        {1'b1, 4'd8,  8'h01, 8'h00, 4'd11},
        {1'b1, 4'd9,  8'h80, 8'h00, 4'd11},
        {1'b0, 4'd8,  8'h00, 8'h01, 4'd11},  // R11 compare 1
        {1'b0, 4'd9,  8'h00, 8'h80, 4'd11},
        {1'b1, 4'd1,  8'hFF, 8'h00, 4'd9},
        {1'b0, 4'd1,  8'h00, 8'h01, 4'd9},   // R9 only bit 0 kept
        {1'b1, 4'd1,  8'h00, 8'h00, 4'd9},
        {1'b0, 4'd1,  8'h00, 8'h00, 4'd9},
        {1'b0, 4'd14, 8'h00, 8'h00, 4'd11},  // R11 unmapped
        {1'b1, 4'd2,  8'h55, 8'h00, 4'd10},
        {1'b0, 4'd2,  8'h00, 8'h00, 4'd10},  // R10 high write ignored
        {1'b0, 4'd0,  8'h00, 8'h00, 4'd11}   // R11 status after table
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic acc(input logic w, input logic [3:0] a, input logic [7:0] d,
                       input logic tk, output logic [7:0] r);
        @(negedge clk);
        addr  = a;
        wr    = w;
        rd    = ~w;
        wdata = d;
        tick  = tk;
        #1 r  = rdata;
        @(negedge clk);
        rd    = 1'b0;
        wr    = 1'b0;
        tick  = 1'b0;
    endtask

    task automatic rdchk(input logic [3:0] a, input logic [7:0] exp, input string req);
        logic [7:0] r;
        acc(1'b0, a, 8'h00, 1'b0, r);
        chk(req, r, exp);
    endtask

    task automatic rdq(input logic [3:0] a);
        logic [7:0] r;
        acc(1'b0, a, 8'h00, 1'b0, r);
    endtask

    task automatic wrr(input logic [3:0] a, input logic [7:0] d);
        logic [7:0] r;
        acc(1'b1, a, d, 1'b0, r);
    endtask

    task automatic run(input int n);
        @(negedge clk);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired actual hung expected done");
        finish_run();
    end

    initial begin
        logic [7:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 compare pins after reset
        chk("R1 cmp0", {7'b0, cmp0_out}, 8'h00);
        chk("R1 cmp1", {7'b0, cmp1_out}, 8'h00);

        for (int i = 0; i < NV; i++) begin
            acc(TBL[i][24], TBL[i][23:20], TBL[i][19:12], 1'b0, r);
            if (!TBL[i][24]) chk($sformatf("R%0d table %0d", TBL[i][3:0], i), r, TBL[i][11:4]);
        end

        // R3 compare 0 match
        wrr(4'd6, 8'h00);
        wrr(4'd7, 8'h05);
        wrr(4'd3, 8'h00);
        run(4);
        rdchk(4'd0, 8'h00, "R3 before match");
        run(1);
        chk("R3 cmp0 pin", {7'b0, cmp0_out}, 8'h01);
        rdchk(4'd0, 8'h02, "R3 status");
        rdchk(4'd7, 8'h05, "R5 clear access");
        rdchk(4'd0, 8'h00, "R5 cleared");
        chk("R5 cmp0 pin low", {7'b0, cmp0_out}, 8'h00);

        // R7 late set, R5 wrong register
        wrr(4'd8, 8'h00);
        wrr(4'd9, 8'h03);
        wrr(4'd3, 8'h00);
        rdchk(4'd0, 8'h00, "R7 arm nothing");
        run(3);
        chk("R3 cmp1 pin", {7'b0, cmp1_out}, 8'h01);
        rdq(4'd9);
        rdchk(4'd0, 8'h04, "R7 not cleared");
        rdq(4'd7);
        chk("R5 wrong register", {7'b0, cmp1_out}, 8'h01);
        rdq(4'd9);
        chk("R5 own register", {7'b0, cmp1_out}, 8'h00);
        rdchk(4'd0, 8'h00, "R5 status clear");
        wrr(4'd8, 8'hF0);
        wrr(4'd9, 8'h00);

        // R8 set and clear in the same cycle
        wrr(4'd3, 8'h00);
        run(5);
        wrr(4'd3, 8'h00);
        rdchk(4'd0, 8'h02, "R8 armed");
        run(4);
        acc(1'b0, 4'd7, 8'h00, 1'b1, r);
        chk("R8 pin after collision", {7'b0, cmp0_out}, 8'h01);
        rdchk(4'd0, 8'h02, "R8 status after collision");
        rdq(4'd7);
        rdchk(4'd0, 8'h00, "R8 later clear");

        // R10 coherent read
        wrr(4'd3, 8'h00);
        run(255);
        acc(1'b0, 4'd2, 8'h00, 1'b1, r);
        chk("R10 high", r, 8'h00);
        rdchk(4'd3, 8'hFF, "R10 latched low");
        rdchk(4'd2, 8'h01, "R10 high again");
        rdchk(4'd3, 8'h00, "R10 low again");
        rdchk(4'd4, 8'h01, "R11 alias high");
        rdchk(4'd5, 8'h00, "R11 alias low");

        // R9 halt, R4 capture while halted
        wrr(4'd1, 8'h01);
        chk("R9 cmp0 forced off", {7'b0, cmp0_out}, 8'h00);
        run(10);
        rdchk(4'd2, 8'h01, "R9 frozen high");
        rdchk(4'd3, 8'h00, "R9 frozen low");
        @(negedge clk);
        cap1_pin = 1'b1;
        repeat (5) @(negedge clk);
        rdchk(4'd12, 8'h01, "R4 cap1 high");
        rdchk(4'd13, 8'h00, "R4 cap1 low");
        rdchk(4'd0, 8'h0A, "R4 cap1 flag");
        rdq(4'd13);
        rdchk(4'd0, 8'h02, "R5 cap1 cleared");
        cap0_pin = 1'b1;
        repeat (5) @(negedge clk);
        rdchk(4'd10, 8'h01, "R4 cap0 high");
        rdchk(4'd11, 8'h00, "R4 cap0 low");
        rdchk(4'd0, 8'h02, "R4 cap0 no flag");
        cap0_pin = 1'b0;
        cap1_pin = 1'b0;
        wrr(4'd3, 8'h00);
        rdchk(4'd2, 8'h00, "R9 reset while halted");
        wrr(4'd1, 8'h00);
        chk("R9 pin back", {7'b0, cmp0_out}, 8'h01);
        rdq(4'd0);
        rdq(4'd7);
        chk("R5 cmp0 cleared", {7'b0, cmp0_out}, 8'h00);

        // R2 wrap, R6 alias
        wrr(4'd3, 8'h00);
        run(65535);
        rdchk(4'd2, 8'hFF, "R2 top high");
        rdchk(4'd3, 8'hFF, "R2 top low");
        acc(1'b0, 4'd0, 8'h00, 1'b0, r);
        chk("R2 no overflow yet", r & 8'h01, 8'h00);
        run(1);
        acc(1'b0, 4'd0, 8'h00, 1'b0, r);
        chk("R2 overflow set", r & 8'h01, 8'h01);
        rdchk(4'd2, 8'h00, "R2 wrapped high");
        rdq(4'd5);
        acc(1'b0, 4'd0, 8'h00, 1'b0, r);
        chk("R6 alias keeps flag", r & 8'h01, 8'h01);
        rdq(4'd3);
        acc(1'b0, 4'd0, 8'h00, 1'b0, r);
        chk("R5 overflow cleared", r & 8'h01, 8'h00);

        finish_run();
    end

endmodule